// File: doc/BRIEF.md
# One-Hot Renaming Scoreboard Matrix

This block is the issue-side bookkeeping of an out-of-order core built around function units that each carry their own operand latches. It keeps a matrix with one row per function unit and one column per architectural register. Each cell holds a single "latest writer" flag. At most one flag per column is set, and the set flag names the unit that will produce the newest value of that register. A column with no flag set means the register file already holds the current value. This one-hot flag does the job of an alias table and needs no tags and no associative search.

One instruction issues per cycle, into the lowest-numbered free unit. For each of its two source registers the block reads the flag column. If the column is clear, the register-file value the caller supplies is latched into the unit. If a flag is set, the block records a read-after-write link from the new unit to the flagged producer instead. The issuing unit then takes ownership of its destination column. A writeback from a unit does four things: it drives the register-file write port with that unit's destination, drops the unit's flag, wakes every operand waiting on it by capturing the result-bus value, and frees the unit on the next cycle.

Top module: `onehot_rename_sb`

## Requirements
- R1: After a synchronous reset, every unit is free (`fu_busy` = 0), no unit is ready (`fu_ready` = 0), `issue_ready` = 1, and every register column is clear, so any source reads the register file.
- R2: In every register column, at most one unit flag is set at any time.
- R3: An issue is accepted only when `issue_valid` = 1 and a free unit exists. It goes to the lowest-numbered free unit, whose index is shown combinationally on `issue_fu`. When all units are busy, `issue_ready` = 0 and an issue request changes no state.
- R4: A source whose column is clear at issue latches its register-file data (`rf_rdata_a` or `rf_rdata_b`) into the unit's operand. A unit is ready the cycle after issue when both of its sources were clear.
- R5: A source whose column holds a flag makes the new unit depend on the flagged unit. That operand latch reads zero, and the unit is not ready, until the producer writes back.
- R6: Issue makes the issuing unit the sole owner of its destination column from the next cycle on, and clears the previous owner's flag. The source lookups of the same issue see the flags as they were before this update.
- R7: With `wb_valid` = 1, `rf_we` = 1, `rf_waddr` = the destination of unit `wb_fu`, and `rf_wdata` = `wb_data`, all in the same cycle. The unit's flag is cleared only if it is still the column owner; a column that a newer issue has claimed keeps its owner.
- R8: On a writeback, every operand waiting on that unit captures `wb_data` and drops the link. A unit becomes ready the cycle after its last link is dropped.
- R9: If an issue reads a source whose flagged producer writes back in the same cycle, the operand takes `wb_data` directly and no link is recorded.
- R10: A unit that writes back is free from the next cycle on. In the writeback cycle itself it cannot be chosen for issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_src_a | input | $clog2(NUM_REG) | First source register |
| issue_src_b | input | $clog2(NUM_REG) | Second source register |
| issue_dst | input | $clog2(NUM_REG) | Destination register |
| issue_ready | output | 1 | At least one unit is free |
| issue_fu | output | $clog2(NUM_FU) | Unit that an issue this cycle goes to |
| rf_rdata_a | input | DATA_W | Register-file value of `issue_src_a` |
| rf_rdata_b | input | DATA_W | Register-file value of `issue_src_b` |
| wb_valid | input | 1 | A unit delivers its result |
| wb_fu | input | $clog2(NUM_FU) | Unit that writes back |
| wb_data | input | DATA_W | Result bus value |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | $clog2(NUM_REG) | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| fu_busy | output | NUM_FU | Unit holds an instruction |
| fu_ready | output | NUM_FU | Unit is busy and has both operands |
| fu_opa | output | NUM_FU*DATA_W | First operand latch of each unit, unit i at bits i*DATA_W upward |
| fu_opb | output | NUM_FU*DATA_W | Second operand latch of each unit, same packing |

## Verification
Issue and writeback can fall in the same cycle. The case that matters is an issuing instruction whose source producer is the very unit writing back, because the register file cannot yet show that value and the column flag is still set. The bench provokes this by holding a dependent issue and the producer's writeback in one cycle. It judges the result by the new unit being ready on the next cycle with the result-bus value in its operand latch, and by the writing unit having become free while a different unit took the issue. The same overlap also covers a writeback from a unit that no longer owns its column, with a later reader still waiting on the newer owner.

// File: rtl/orm_pkg.sv
package orm_pkg;

    // Where an issuing operand gets its value from
    typedef enum logic [1:0] {
        OPS_REGFILE    = 2'd0,
        OPS_RESULT_BUS = 2'd1,
        OPS_WAIT       = 2'd2
    } opnd_src_e;

    // Decide operand source from the column lookup and a same-cycle writeback hit
    function automatic opnd_src_e pick_src(input logic col_hit, input logic wb_hit);
        if (!col_hit)
            return OPS_REGFILE;
        if (wb_hit)
            return OPS_RESULT_BUS;
        return OPS_WAIT;
    endfunction

endpackage

// File: rtl/orm_alloc.sv
module orm_alloc #(
    parameter int NUM_FU = 8,
    localparam int FW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic [NUM_FU-1:0] busy,
    output logic              any_free,
    output logic [FW-1:0]     free_idx
);

    // Lowest-numbered free unit wins
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = FW'(i);
            end
        end
    end

endmodule

// File: rtl/orm_writer_matrix.sv
module orm_writer_matrix #(
    parameter int NUM_FU  = 8,
    parameter int NUM_REG = 32,
    localparam int FW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int RW = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RW-1:0]     look_a,
    input  logic [RW-1:0]     look_b,
    output logic [NUM_FU-1:0] owner_a,
    output logic [NUM_FU-1:0] owner_b,
    input  logic              claim_en,
    input  logic [FW-1:0]     claim_fu,
    input  logic [RW-1:0]     claim_reg,
    input  logic              rel_en,
    input  logic [FW-1:0]     rel_fu,
    input  logic [RW-1:0]     rel_reg
);

    logic [NUM_REG-1:0] flag_q [NUM_FU];
    logic [NUM_REG-1:0] flag_d [NUM_FU];
    logic [NUM_FU-1:0]  col_q  [NUM_REG];

    // Column view of the row-organised flags
    always_comb begin
        for (int r = 0; r < NUM_REG; r++) begin
            for (int f = 0; f < NUM_FU; f++) begin
                col_q[r][f] = flag_q[f][r];
            end
        end
    end

    // Lookups read the pre-update state
    assign owner_a = col_q[look_a];
    assign owner_b = col_q[look_b];

    // Release first, then claim: a claim overrides the whole destination column
    always_comb begin
        for (int f = 0; f < NUM_FU; f++) begin
            flag_d[f] = flag_q[f];
            if (rel_en && (rel_fu == FW'(f)))
                flag_d[f][rel_reg] = 1'b0;
            if (claim_en)
                flag_d[f][claim_reg] = (claim_fu == FW'(f));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < NUM_FU; f++)
                flag_q[f] <= '0;
        end else begin
            for (int f = 0; f < NUM_FU; f++)
                flag_q[f] <= flag_d[f];
        end
    end

    // R2: a column never names more than one writer
    for (genvar r = 0; r < NUM_REG; r++) begin : g_col_chk
        a_r2_col_onehot: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col_q[r]));
    end

    // R6: the claiming unit owns the column on the next cycle
    a_r6_claim_visible: assert property (@(posedge clk) disable iff (rst)
        claim_en |=> flag_q[$past(claim_fu)][$past(claim_reg)]);

    // R7: a released flag is gone on the next cycle
    a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
        (rel_en && !(claim_en && claim_fu == rel_fu)) |=> !flag_q[$past(rel_fu)][$past(rel_reg)]);

endmodule

// File: rtl/orm_operand_latch.sv
module orm_operand_latch #(
    parameter int NUM_FU = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NUM_FU-1:0] wait_on,
    input  logic [DATA_W-1:0] load_data,
    input  logic              wb_en,
    input  logic [NUM_FU-1:0] wb_oh,
    input  logic [DATA_W-1:0] wb_data,
    output logic              pending,
    output logic [DATA_W-1:0] value
);

    logic [NUM_FU-1:0] link_q;
    logic [DATA_W-1:0] val_q;
    logic              wake;

    assign wake = wb_en && ((link_q & wb_oh) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= '0;
            val_q  <= '0;
        end else if (load) begin
            link_q <= wait_on;
            val_q  <= (wait_on != '0) ? '0 : load_data;
        end else if (wake) begin
            link_q <= '0;
            val_q  <= wb_data;
        end
    end

    assign pending = (link_q != '0);
    assign value   = val_q;

    // R5: one operand depends on at most one producer
    a_r5_link_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(link_q));

    // R8: a waiting operand takes the result bus and drops its link
    a_r8_wake_capture: assert property (@(posedge clk) disable iff (rst)
        (!load && wb_en && ((link_q & wb_oh) != '0)) |=> (link_q == '0 && val_q == $past(wb_data)));

endmodule

// File: rtl/orm_unit_slot.sv
module orm_unit_slot #(
    parameter int NUM_FU  = 8,
    parameter int NUM_REG = 32,
    parameter int DATA_W  = 32,
    localparam int RW = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_en,
    input  logic [RW-1:0]     iss_dst,
    input  logic [NUM_FU-1:0] a_wait,
    input  logic [DATA_W-1:0] a_data,
    input  logic [NUM_FU-1:0] b_wait,
    input  logic [DATA_W-1:0] b_data,
    input  logic              wb_en,
    input  logic [NUM_FU-1:0] wb_oh,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              self_wb,
    output logic              busy_o,
    output logic              ready_o,
    output logic [RW-1:0]     dst_o,
    output logic [DATA_W-1:0] opa_o,
    output logic [DATA_W-1:0] opb_o
);

    logic          busy_q;
    logic [RW-1:0] dst_q;
    logic          pend_a;
    logic          pend_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            dst_q  <= '0;
        end else if (iss_en) begin
            busy_q <= 1'b1;
            dst_q  <= iss_dst;
        end else if (self_wb) begin
            busy_q <= 1'b0;
        end
    end

    orm_operand_latch #(.NUM_FU(NUM_FU), .DATA_W(DATA_W)) u_opa (
        .clk(clk), .rst(rst), .load(iss_en), .wait_on(a_wait), .load_data(a_data),
        .wb_en(wb_en), .wb_oh(wb_oh), .wb_data(wb_data),
        .pending(pend_a), .value(opa_o)
    );

    orm_operand_latch #(.NUM_FU(NUM_FU), .DATA_W(DATA_W)) u_opb (
        .clk(clk), .rst(rst), .load(iss_en), .wait_on(b_wait), .load_data(b_data),
        .wb_en(wb_en), .wb_oh(wb_oh), .wb_data(wb_data),
        .pending(pend_b), .value(opb_o)
    );

    assign busy_o  = busy_q;
    assign ready_o = busy_q && !pend_a && !pend_b;
    assign dst_o   = dst_q;

    // R3: issue only lands in a free unit
    a_r3_issue_into_free: assert property (@(posedge clk) disable iff (rst)
        iss_en |-> !busy_q);

    // R10: a unit that writes back is free on the next cycle
    a_r10_free_after_wb: assert property (@(posedge clk) disable iff (rst)
        (self_wb && !iss_en) |=> !busy_q);

endmodule

// File: rtl/onehot_rename_sb.sv
module onehot_rename_sb
    import orm_pkg::*;
#(
    parameter int NUM_FU  = 8,
    parameter int NUM_REG = 32,
    parameter int DATA_W  = 32,
    localparam int FW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int RW = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     issue_valid,
    input  logic [RW-1:0]            issue_src_a,
    input  logic [RW-1:0]            issue_src_b,
    input  logic [RW-1:0]            issue_dst,
    output logic                     issue_ready,
    output logic [FW-1:0]            issue_fu,
    input  logic [DATA_W-1:0]        rf_rdata_a,
    input  logic [DATA_W-1:0]        rf_rdata_b,
    input  logic                     wb_valid,
    input  logic [FW-1:0]            wb_fu,
    input  logic [DATA_W-1:0]        wb_data,
    output logic                     rf_we,
    output logic [RW-1:0]            rf_waddr,
    output logic [DATA_W-1:0]        rf_wdata,
    output logic [NUM_FU-1:0]        fu_busy,
    output logic [NUM_FU-1:0]        fu_ready,
    output logic [NUM_FU*DATA_W-1:0] fu_opa,
    output logic [NUM_FU*DATA_W-1:0] fu_opb
);

    logic              fire;
    logic [NUM_FU-1:0] wb_oh;
    logic [NUM_FU-1:0] owner_a, owner_b;
    logic [NUM_FU-1:0] wait_a, wait_b;
    logic [DATA_W-1:0] data_a, data_b;
    opnd_src_e         sel_a, sel_b;
    logic [RW-1:0]     dst_w [NUM_FU];

    orm_alloc #(.NUM_FU(NUM_FU)) u_alloc (
        .busy(fu_busy), .any_free(issue_ready), .free_idx(issue_fu)
    );

    assign fire = issue_valid && issue_ready;

    always_comb begin
        wb_oh = '0;
        wb_oh[wb_fu] = 1'b1;
    end

    // Destination of the writing unit drives the register-file write port
    always_comb begin
        rf_waddr = '0;
        for (int f = 0; f < NUM_FU; f++) begin
            if (wb_fu == FW'(f))
                rf_waddr = dst_w[f];
        end
    end

    assign rf_we    = wb_valid;
    assign rf_wdata = wb_data;

    orm_writer_matrix #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_matrix (
        .clk(clk), .rst(rst),
        .look_a(issue_src_a), .look_b(issue_src_b),
        .owner_a(owner_a), .owner_b(owner_b),
        .claim_en(fire), .claim_fu(issue_fu), .claim_reg(issue_dst),
        .rel_en(wb_valid), .rel_fu(wb_fu), .rel_reg(rf_waddr)
    );

    // Operand source choice, including bypass from a same-cycle writeback
    always_comb begin
        sel_a  = pick_src(owner_a != '0, wb_valid && ((owner_a & wb_oh) != '0));
        sel_b  = pick_src(owner_b != '0, wb_valid && ((owner_b & wb_oh) != '0));
        data_a = (sel_a == OPS_RESULT_BUS) ? wb_data : rf_rdata_a;
        data_b = (sel_b == OPS_RESULT_BUS) ? wb_data : rf_rdata_b;
        wait_a = (sel_a == OPS_WAIT) ? owner_a : '0;
        wait_b = (sel_b == OPS_WAIT) ? owner_b : '0;
    end

    for (genvar f = 0; f < NUM_FU; f++) begin : g_slot
        orm_unit_slot #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG), .DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst(rst),
            .iss_en(fire && (issue_fu == FW'(f))),
            .iss_dst(issue_dst),
            .a_wait(wait_a), .a_data(data_a),
            .b_wait(wait_b), .b_data(data_b),
            .wb_en(wb_valid), .wb_oh(wb_oh), .wb_data(wb_data),
            .self_wb(wb_valid && (wb_fu == FW'(f))),
            .busy_o(fu_busy[f]), .ready_o(fu_ready[f]), .dst_o(dst_w[f]),
            .opa_o(fu_opa[f*DATA_W +: DATA_W]), .opb_o(fu_opb[f*DATA_W +: DATA_W])
        );
    end

    // R9: a same-cycle bypassed operand leaves the new unit without a link
    a_r9_bypass_no_link: assert property (@(posedge clk) disable iff (rst)
        (fire && sel_a != OPS_WAIT && sel_b != OPS_WAIT) |=> fu_ready[$past(issue_fu)]);

    // R3: nothing issues while every unit is busy
    a_r3_full_no_issue: assert property (@(posedge clk) disable iff (rst)
        (fu_busy == '1) |-> !issue_ready);

endmodule

// File: tb/onehot_rename_sb_tb_top.sv
module onehot_rename_sb_tb_top;

    localparam int NF = 8;
    localparam int NR = 32;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            issue_valid = 1'b0;
    logic [4:0]      issue_src_a = '0, issue_src_b = '0, issue_dst = '0;
    logic            issue_ready;
    logic [2:0]      issue_fu;
    logic [DW-1:0]   rf_rdata_a = '0, rf_rdata_b = '0;
    logic            wb_valid = 1'b0;
    logic [2:0]      wb_fu = '0;
    logic [DW-1:0]   wb_data = '0;
    logic            rf_we;
    logic [4:0]      rf_waddr;
    logic [DW-1:0]   rf_wdata;
    logic [NF-1:0]   fu_busy, fu_ready;
    logic [NF*DW-1:0] fu_opa, fu_opb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    onehot_rename_sb #(.NUM_FU(NF), .NUM_REG(NR), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
        .issue_dst(issue_dst), .issue_ready(issue_ready), .issue_fu(issue_fu),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .wb_valid(wb_valid), .wb_fu(wb_fu), .wb_data(wb_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .fu_busy(fu_busy), .fu_ready(fu_ready), .fu_opa(fu_opa), .fu_opb(fu_opb)
    );

    typedef struct packed {
        logic        iv;
        logic [4:0]  sa;
        logic [4:0]  sb;
        logic [4:0]  dst;
        logic [31:0] rfa;
        logic [31:0] rfb;
        logic        wv;
        logic [2:0]  wfu;
        logic [31:0] wd;
        logic [2:0]  efu;
        logic [4:0]  ewa;
        logic [7:0]  ebusy;
        logic [7:0]  eready;
        logic [2:0]  cfu;
        logic [31:0] eopa;
        logic [31:0] eopb;
    } vec_t;

    // One dependent sequence; each row: stimulus, expected comb outputs, expected state after the edge
    localparam vec_t VEC [8] = '{
        '{1'b1, 5'd1, 5'd2, 5'd3, 32'h11,   32'h22,   1'b0, 3'd0, 32'h0,  3'd0, 5'd0, 8'h01, 8'h01, 3'd0, 32'h11, 32'h22},
        '{1'b1, 5'd3, 5'd1, 5'd4, 32'hDEAD, 32'h33,   1'b0, 3'd0, 32'h0,  3'd1, 5'd0, 8'h03, 8'h01, 3'd1, 32'h0,  32'h33},
        '{1'b1, 5'd4, 5'd3, 5'd3, 32'hDEAD, 32'hDEAD, 1'b0, 3'd0, 32'h0,  3'd2, 5'd0, 8'h07, 8'h01, 3'd2, 32'h0,  32'h0},
        '{1'b0, 5'd0, 5'd0, 5'd0, 32'h0,    32'h0,    1'b1, 3'd0, 32'h55, 3'd0, 5'd3, 8'h06, 8'h02, 3'd2, 32'h0,  32'h55},
        '{1'b1, 5'd3, 5'd0, 5'd5, 32'hDEAD, 32'h10,   1'b0, 3'd0, 32'h0,  3'd0, 5'd0, 8'h07, 8'h02, 3'd0, 32'h0,  32'h10},
        '{1'b1, 5'd4, 5'd9, 5'd6, 32'hDEAD, 32'h99,   1'b1, 3'd1, 32'h66, 3'd3, 5'd4, 8'h0D, 8'h0C, 3'd3, 32'h66, 32'h99},
        '{1'b0, 5'd0, 5'd0, 5'd0, 32'h0,    32'h0,    1'b1, 3'd2, 32'h77, 3'd0, 5'd3, 8'h09, 8'h09, 3'd0, 32'h77, 32'h10},
        '{1'b1, 5'd3, 5'd5, 5'd7, 32'hAB,   32'hCD,   1'b0, 3'd0, 32'h0,  3'd1, 5'd0, 8'h0B, 8'h09, 3'd1, 32'hAB, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] opa_of(input int f);
        return fu_opa[f*DW +: DW];
    endfunction

    function automatic logic [31:0] opb_of(input int f);
        return fu_opb[f*DW +: DW];
    endfunction

    // Drive one cycle at the falling edge, return 1 ns after the rising edge
    task automatic cyc(input logic iv, input logic [4:0] sa, input logic [4:0] sb, input logic [4:0] d,
                       input logic [31:0] ra, input logic [31:0] rb,
                       input logic wv, input logic [2:0] wf, input logic [31:0] wd);
        @(negedge clk);
        issue_valid = iv; issue_src_a = sa; issue_src_b = sb; issue_dst = d;
        rf_rdata_a = ra; rf_rdata_b = rb; wb_valid = wv; wb_fu = wf; wb_data = wd;
        @(posedge clk);
        #1;
        issue_valid = 1'b0; wb_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; issue_valid = 1'b0; wb_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();

        // R1: reset state
        chk("R1 busy after reset", 32'(fu_busy), 32'h0);
        chk("R1 ready after reset", 32'(fu_ready), 32'h0);
        chk("R1 issue_ready after reset", 32'(issue_ready), 32'h1);

        // Vector table walk: R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            issue_valid = VEC[i].iv; issue_src_a = VEC[i].sa; issue_src_b = VEC[i].sb;
            issue_dst = VEC[i].dst; rf_rdata_a = VEC[i].rfa; rf_rdata_b = VEC[i].rfb;
            wb_valid = VEC[i].wv; wb_fu = VEC[i].wfu; wb_data = VEC[i].wd;
            #1;
            if (VEC[i].iv) begin
                chk($sformatf("R3 issue_fu step %0d", i), 32'(issue_fu), 32'(VEC[i].efu));
                chk($sformatf("R3 issue_ready step %0d", i), 32'(issue_ready), 32'h1);
            end
            if (VEC[i].wv) begin
                chk($sformatf("R7 rf_we step %0d", i), 32'(rf_we), 32'h1);
                chk($sformatf("R7 rf_waddr step %0d", i), 32'(rf_waddr), 32'(VEC[i].ewa));
                chk($sformatf("R7 rf_wdata step %0d", i), rf_wdata, VEC[i].wd);
            end
            @(posedge clk);
            #1;
            issue_valid = 1'b0; wb_valid = 1'b0;
            chk($sformatf("R10 busy step %0d", i), 32'(fu_busy), 32'(VEC[i].ebusy));
            chk($sformatf("R4/R5/R8/R9 ready step %0d", i), 32'(fu_ready), 32'(VEC[i].eready));
            chk($sformatf("R4/R8/R9 opa step %0d", i), opa_of(int'(VEC[i].cfu)), VEC[i].eopa);
            chk($sformatf("R4/R5/R6 opb step %0d", i), opb_of(int'(VEC[i].cfu)), VEC[i].eopb);
        end

        // R1: reset clears ownership; r3 and r5 were owned above
        do_reset();
        chk("R1 busy after second reset", 32'(fu_busy), 32'h0);
        cyc(1'b1, 5'd3, 5'd5, 5'd8, 32'h3333, 32'h5555, 1'b0, 3'd0, 32'h0);
        chk("R1 clean column ready", 32'(fu_ready), 32'h1);
        chk("R1 clean column opa", opa_of(0), 32'h3333);
        chk("R1 clean column opb", opb_of(0), 32'h5555);

        // R3: fill all units, then an issue while full is ignored
        do_reset();
        for (int k = 0; k < NF; k++)
            cyc(1'b1, 5'd0, 5'd0, 5'(10 + k), 32'h1, 32'h2, 1'b0, 3'd0, 32'h0);
        chk("R3 all busy", 32'(fu_busy), 32'hFF);
        chk("R3 issue_ready low when full", 32'(issue_ready), 32'h0);
        cyc(1'b1, 5'd0, 5'd0, 5'd20, 32'h1, 32'h2, 1'b0, 3'd0, 32'h0);
        chk("R3 full issue leaves busy", 32'(fu_busy), 32'hFF);
        cyc(1'b0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0, 1'b1, 3'd0, 32'h44);
        chk("R10 unit 0 freed", 32'(fu_busy), 32'hFE);
        // r20 must still be clean: the ignored issue claimed nothing
        cyc(1'b1, 5'd20, 5'd0, 5'd21, 32'h2020, 32'h7, 1'b0, 3'd0, 32'h0);
        chk("R3 ignored issue claimed no column", 32'(fu_ready[0]), 32'h1);
        chk("R3 ignored issue opa", opa_of(0), 32'h2020);

        // R6: self-source lookup sees the old owner; newest claim wins the column
        do_reset();
        cyc(1'b1, 5'd1, 5'd1, 5'd1, 32'hA1, 32'hA1, 1'b0, 3'd0, 32'h0);
        cyc(1'b1, 5'd1, 5'd1, 5'd1, 32'hDEAD, 32'hDEAD, 1'b0, 3'd0, 32'h0);
        chk("R6 self-source waits on old owner", 32'(fu_ready), 32'h1);
        cyc(1'b1, 5'd1, 5'd2, 5'd2, 32'hDEAD, 32'hB2, 1'b0, 3'd0, 32'h0);
        cyc(1'b0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0, 1'b1, 3'd0, 32'hAA);
        chk("R8 unit 1 woken by unit 0", 32'(fu_ready), 32'h2);
        chk("R8 unit 1 opa", opa_of(1), 32'hAA);
        chk("R8 unit 1 opb", opb_of(1), 32'hAA);
        chk("R6 unit 2 still waits on newest owner", opa_of(2), 32'h0);
        cyc(1'b0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0, 1'b1, 3'd1, 32'hBB);
        chk("R6 unit 2 woken by newest owner", 32'(fu_ready), 32'h4);
        chk("R6 unit 2 opa", opa_of(2), 32'hBB);
        chk("R4 unit 2 opb", opb_of(2), 32'hB2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule